// File: doc/BRIEF.md
# Predicate File and Slot Gating for a Three-Slot VLIW Core

This block keeps the one-bit predicates that a three-slot VLIW core uses to turn single operations of an issued bundle on or off. Compare operations test a signed register value against zero under one of six conditions. Each one writes its true/false result into a predicate bit that the operation selects. In the same cycle the block looks at each slot of the bundle being issued. These slots are the integer ALU/branch slot (slot 0), the load/store slot (slot 1) and the floating-point add/multiply slot (slot 2). For each slot it raises an execute-enable only if the slot holds an operation and that operation is either unpredicated or names a predicate that is currently set.

The block has several compare ports. A bundle in which two compares target the same predicate bit writes one destination twice, so the block flags it as illegal and drops both writes. Reads come from the predicate values as they stood at the start of the cycle. A compare result is therefore visible to bundles from the next cycle on. A branch in the ALU slot is never predicated.

Top module: `vliw_pred_unit`

## Requirements
- R1: After reset every predicate bit is clear, so a valid slot that is predicated on any index 0..31 gets no execute-enable.
- R2: A valid compare with operation code 0 (value < 0), 1 (<= 0), 2 (> 0), 3 (>= 0), 4 (== 0) or 5 (!= 0) treats the 32-bit value as two's complement. It writes the truth of the condition into the predicate at its 5-bit destination index, and the new value is seen by gating from the next cycle on.
- R3: A compare with operation code 6 or 7 writes no predicate and never counts towards a double-write clash.
- R4: A valid non-branch slot is enabled when its predicate-enable is low, or when its predicate-enable is high and the predicate at its index is set. Otherwise it is not enabled.
- R5: A slot whose valid flag is low never gets an execute-enable, whatever its predicate fields hold.
- R6: When slot 0 is valid and carries a branch, it is enabled whatever its predicate-enable and predicate index say.
- R7: Gating in a cycle uses the predicate values from before any compare issued in that same cycle.
- R8: When two valid compares with codes 0..5 in one cycle name the same destination index, the illegal-bundle flag is high in that cycle and neither write takes effect.
- R9: Valid compares that name distinct destination indices in one cycle all write, and the illegal-bundle flag stays low.
- R10: A predicate bit keeps its value across idle cycles until a compare writes it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | NUM_CMP (2) | Per compare port: request present |
| cmp_op | input | NUM_CMP*3 (6) | Per port condition code, port p at bits [3p+2:3p] |
| cmp_dst | input | NUM_CMP*5 (10) | Per port destination predicate index, port p at [5p+4:5p] |
| cmp_val | input | NUM_CMP*32 (64) | Per port signed register value, port p at [32p+31:32p] |
| slot_valid | input | 3 | Per slot: operation present (bit 0 ALU/branch, 1 load/store, 2 FP) |
| slot_pred_en | input | 3 | Per slot: operation is predicated |
| slot_pred_idx | input | 15 | Per slot predicate index, slot s at [5s+4:5s] |
| alu_is_branch | input | 1 | Slot 0 holds a control operation |
| slot_exec | output | 3 | Per slot execute-enable |
| bundle_illegal | output | 1 | Two compares in this cycle target one predicate |

## Verification
The execute-enables and the illegal flag are combinational from the current inputs and the stored predicates, so they are due in the same cycle as the stimulus. A compare write lands at the next rising edge and shows in the gating one cycle later. The bench drives each bundle just after a falling edge and samples one nanosecond later, which is before the next rising edge. After a compare it waits for the following falling edge before it probes the written bit through a predicated load/store slot. The same-cycle case holds the compare and the predicated slot together, checks the old value before the edge, and then checks the new value after it.

// File: rtl/vliw_pred_pkg.sv
`timescale 1ns/1ps
package vliw_pred_pkg;

    typedef enum logic [2:0] {
        CMP_LTZ  = 3'd0,
        CMP_LEZ  = 3'd1,
        CMP_GTZ  = 3'd2,
        CMP_GEZ  = 3'd3,
        CMP_EQZ  = 3'd4,
        CMP_NEZ  = 3'd5,
        CMP_RSV6 = 3'd6,
        CMP_RSV7 = 3'd7
    } cmp_op_e;

    localparam int OP_W     = 3;
    localparam int SLOT_ALU = 0;
    localparam int SLOT_MEM = 1;
    localparam int SLOT_FPU = 2;

endpackage

// File: rtl/pred_cmp_eval.sv
`timescale 1ns/1ps
module pred_cmp_eval
    import vliw_pred_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] val_i,
    output logic              hit_o,
    output logic              writes_o
);

    logic is_neg;
    logic is_zero;

    assign is_neg  = val_i[DATA_W-1];
    assign is_zero = (val_i == '0);

    always_comb begin
        hit_o    = 1'b0;
        writes_o = 1'b1;
        unique case (cmp_op_e'(op_i))
            CMP_LTZ:  hit_o = is_neg;
            CMP_LEZ:  hit_o = is_neg | is_zero;
            CMP_GTZ:  hit_o = ~is_neg & ~is_zero;
            CMP_GEZ:  hit_o = ~is_neg;
            CMP_EQZ:  hit_o = is_zero;
            CMP_NEZ:  hit_o = ~is_zero;
            CMP_RSV6,
            CMP_RSV7: writes_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pred_collide.sv
`timescale 1ns/1ps
module pred_collide #(
    parameter int NUM_CMP = 2,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_CMP-1:0]       wr_req_i,
    input  logic [NUM_CMP*IDX_W-1:0] dst_i,
    output logic [NUM_CMP-1:0]       clash_o,
    output logic                     any_clash_o
);

    always_comb begin
        clash_o = '0;
        for (int i = 0; i < NUM_CMP; i++) begin
            for (int j = 0; j < NUM_CMP; j++) begin
                if (i != j && wr_req_i[i] && wr_req_i[j] &&
                    dst_i[i*IDX_W +: IDX_W] == dst_i[j*IDX_W +: IDX_W]) begin
                    clash_o[i] = 1'b1;
                end
            end
        end
    end

    assign any_clash_o = |clash_o;

endmodule

// File: rtl/pred_regfile.sv
`timescale 1ns/1ps
module pred_regfile #(
    parameter int PREDS   = 32,
    parameter int NUM_CMP = 2,
    parameter int IDX_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CMP-1:0]       wr_en_i,
    input  logic [NUM_CMP*IDX_W-1:0] wr_idx_i,
    input  logic [NUM_CMP-1:0]       wr_bit_i,
    output logic [PREDS-1:0]         pred_q
);

    logic [PREDS-1:0] pred_d;

    always_comb begin
        pred_d = pred_q;
        for (int p = 0; p < NUM_CMP; p++) begin
            if (wr_en_i[p]) begin
                pred_d[wr_idx_i[p*IDX_W +: IDX_W]] = wr_bit_i[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else begin
            pred_q <= pred_d;
        end
    end

endmodule

// File: rtl/pred_slot_gate.sv
`timescale 1ns/1ps
module pred_slot_gate #(
    parameter int PREDS = 32,
    parameter int IDX_W = 5
) (
    input  logic             valid_i,
    input  logic             pred_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             is_ctrl_i,
    input  logic [PREDS-1:0] preds_i,
    output logic             exec_o
);

    logic use_pred;

    assign use_pred = pred_en_i & ~is_ctrl_i;

    always_comb begin
        if (!valid_i) begin
            exec_o = 1'b0;
        end else if (use_pred) begin
            exec_o = preds_i[idx_i];
        end else begin
            exec_o = 1'b1;
        end
    end

endmodule

// File: rtl/vliw_pred_unit.sv
`timescale 1ns/1ps
module vliw_pred_unit
    import vliw_pred_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PREDS   = 32,
    parameter int NUM_CMP = 2,
    parameter int SLOTS   = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_CMP-1:0]                  cmp_valid,
    input  logic [NUM_CMP*OP_W-1:0]             cmp_op,
    input  logic [NUM_CMP*$clog2(PREDS)-1:0]    cmp_dst,
    input  logic [NUM_CMP*DATA_W-1:0]           cmp_val,
    input  logic [SLOTS-1:0]                    slot_valid,
    input  logic [SLOTS-1:0]                    slot_pred_en,
    input  logic [SLOTS*$clog2(PREDS)-1:0]      slot_pred_idx,
    input  logic                                alu_is_branch,
    output logic [SLOTS-1:0]                    slot_exec,
    output logic                                bundle_illegal
);

    localparam int IDX_W = $clog2(PREDS);

    logic [NUM_CMP-1:0] cmp_hit;
    logic [NUM_CMP-1:0] cmp_writes;
    logic [NUM_CMP-1:0] cmp_req;
    logic [NUM_CMP-1:0] cmp_clash;
    logic [NUM_CMP-1:0] cmp_wr_en;
    logic [PREDS-1:0]   preds;

    for (genvar p = 0; p < NUM_CMP; p++) begin : g_cmp
        pred_cmp_eval #(.DATA_W(DATA_W)) eval_i (
            .op_i     (cmp_op[p*OP_W +: OP_W]),
            .val_i    (cmp_val[p*DATA_W +: DATA_W]),
            .hit_o    (cmp_hit[p]),
            .writes_o (cmp_writes[p])
        );
        assign cmp_req[p]   = cmp_valid[p] & cmp_writes[p];
        assign cmp_wr_en[p] = cmp_req[p] & ~cmp_clash[p];
    end

    pred_collide #(.NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) collide_i (
        .wr_req_i    (cmp_req),
        .dst_i       (cmp_dst),
        .clash_o     (cmp_clash),
        .any_clash_o (bundle_illegal)
    );

    pred_regfile #(.PREDS(PREDS), .NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) file_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (cmp_wr_en),
        .wr_idx_i (cmp_dst),
        .wr_bit_i (cmp_hit),
        .pred_q   (preds)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic slot_ctrl;
        if (s == SLOT_ALU) begin : g_alu
            assign slot_ctrl = alu_is_branch;
        end else begin : g_other
            assign slot_ctrl = 1'b0;
        end
        pred_slot_gate #(.PREDS(PREDS), .IDX_W(IDX_W)) gate_i (
            .valid_i   (slot_valid[s]),
            .pred_en_i (slot_pred_en[s]),
            .idx_i     (slot_pred_idx[s*IDX_W +: IDX_W]),
            .is_ctrl_i (slot_ctrl),
            .preds_i   (preds),
            .exec_o    (slot_exec[s])
        );
    end

endmodule

// File: rtl/vliw_pred_unit_chk.sv
`timescale 1ns/1ps
module vliw_pred_unit_chk
    import vliw_pred_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PREDS   = 32,
    parameter int NUM_CMP = 2,
    parameter int SLOTS   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CMP-1:0]               cmp_valid,
    input  logic [NUM_CMP*OP_W-1:0]          cmp_op,
    input  logic [NUM_CMP*$clog2(PREDS)-1:0] cmp_dst,
    input  logic [NUM_CMP*DATA_W-1:0]        cmp_val,
    input  logic [SLOTS-1:0]                 slot_valid,
    input  logic [SLOTS-1:0]                 slot_pred_en,
    input  logic [SLOTS*$clog2(PREDS)-1:0]   slot_pred_idx,
    input  logic                             alu_is_branch,
    input  logic [SLOTS-1:0]                 slot_exec,
    input  logic                             bundle_illegal
);

    localparam int IDX_W = $clog2(PREDS);

    logic p0_sets_gtz;
    assign p0_sets_gtz = (cmp_valid == NUM_CMP'(1)) &&
                         (cmp_op[OP_W-1:0] == CMP_GTZ) &&
                         !cmp_val[DATA_W-1] && (cmp_val[DATA_W-1:0] != '0);

    assert_exec_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_exec & ~slot_valid) == '0));

    assert_unpredicated_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid & ~slot_pred_en & ~slot_exec) == '0));

    assert_branch_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid[SLOT_ALU] && alu_is_branch) |-> slot_exec[SLOT_ALU]);

    assert_lone_write_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmp_valid) <= 1) |-> !bundle_illegal);

    assert_gtz_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        p0_sets_gtz |=> ((slot_valid[SLOT_MEM] && slot_pred_en[SLOT_MEM] &&
                          slot_pred_idx[SLOT_MEM*IDX_W +: IDX_W] == $past(cmp_dst[IDX_W-1:0]))
                         -> slot_exec[SLOT_MEM]));

    if (NUM_CMP >= 2) begin : g_pair
        assert_clash_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_valid[0] && cmp_valid[1] &&
             cmp_op[OP_W-1:0] < 3'd6 && cmp_op[2*OP_W-1:OP_W] < 3'd6 &&
             cmp_dst[IDX_W-1:0] == cmp_dst[2*IDX_W-1:IDX_W]) |-> bundle_illegal);
    end

endmodule

bind vliw_pred_unit vliw_pred_unit_chk #(
    .DATA_W(DATA_W), .PREDS(PREDS), .NUM_CMP(NUM_CMP), .SLOTS(SLOTS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmp_valid      (cmp_valid),
    .cmp_op         (cmp_op),
    .cmp_dst        (cmp_dst),
    .cmp_val        (cmp_val),
    .slot_valid     (slot_valid),
    .slot_pred_en   (slot_pred_en),
    .slot_pred_idx  (slot_pred_idx),
    .alu_is_branch  (alu_is_branch),
    .slot_exec      (slot_exec),
    .bundle_illegal (bundle_illegal)
);

// File: tb/vliw_pred_unit_tb_top.sv
`timescale 1ns/1ps
module vliw_pred_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmp_valid = '0;
    logic [5:0]  cmp_op = '0;
    logic [9:0]  cmp_dst = '0;
    logic [63:0] cmp_val = '0;
    logic [2:0]  slot_valid = '0;
    logic [2:0]  slot_pred_en = '0;
    logic [14:0] slot_pred_idx = '0;
    logic        alu_is_branch = 1'b0;
    logic [2:0]  slot_exec;
    logic        bundle_illegal;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  exp_p [32];

    always #2.5 clk = ~clk;

    vliw_pred_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_op(cmp_op), .cmp_dst(cmp_dst), .cmp_val(cmp_val),
        .slot_valid(slot_valid), .slot_pred_en(slot_pred_en), .slot_pred_idx(slot_pred_idx),
        .alu_is_branch(alu_is_branch), .slot_exec(slot_exec), .bundle_illegal(bundle_illegal)
    );

    function automatic bit ref_cmp(int op, logic [31:0] v);
        case (op)
            0: return $signed(v) < 0;
            1: return $signed(v) <= 0;
            2: return $signed(v) > 0;
            3: return $signed(v) >= 0;
            4: return v == 0;
            default: return v != 0;
        endcase
    endfunction

    task automatic check(logic got, logic exp, string req, string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic idle();
        cmp_valid = '0; slot_valid = '0; slot_pred_en = '0; alu_is_branch = 1'b0;
    endtask

    task automatic probe(int idx, string req);
        @(negedge clk);
        idle();
        slot_valid[1] = 1'b1; slot_pred_en[1] = 1'b1; slot_pred_idx[5 +: 5] = idx[4:0];
        #1;
        check(slot_exec[1], exp_p[idx], req, $sformatf("predicate %0d", idx));
        idle();
    endtask

    task automatic set_cmp(int port, int op, int dst, logic [31:0] v);
        cmp_valid[port] = 1'b1;
        cmp_op[port*3 +: 3] = op[2:0];
        cmp_dst[port*5 +: 5] = dst[4:0];
        cmp_val[port*32 +: 32] = v;
    endtask

    task automatic issue_cmp(int port, int op, int dst, logic [31:0] v);
        @(negedge clk);
        idle();
        set_cmp(port, op, dst, v);
        if (op < 6) exp_p[dst] = ref_cmp(op, v);
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) probe(i, "R1");
        check(bundle_illegal, 1'b0, "R1", "illegal flag at reset");
    endtask

    task automatic t_compares();
        logic [31:0] vals [5];
        vals[0] = 32'hFFFF_FFFB; vals[1] = 32'h0; vals[2] = 32'd7;
        vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF;
        for (int vi = 0; vi < 5; vi++) begin
            for (int op = 0; op < 6; op++) begin
                int dst = (vi * 6 + op) % 32;
                issue_cmp(op % 2, op, dst, vals[vi]);
                probe(dst, "R2");
            end
        end
    endtask

    task automatic t_reserved();
        issue_cmp(0, 3, 20, 32'd0);
        issue_cmp(0, 6, 20, 32'hFFFF_FFFF);
        probe(20, "R3");
        issue_cmp(1, 4, 20, 32'd5);
        issue_cmp(1, 7, 20, 32'd0);
        probe(20, "R3");
    endtask

    task automatic t_gating();
        issue_cmp(0, 2, 5, 32'd1);
        issue_cmp(0, 4, 6, 32'd1);
        @(negedge clk);
        slot_valid = 3'b111; slot_pred_en = 3'b110;
        slot_pred_idx = {5'd6, 5'd5, 5'd6};
        #1;
        check(slot_exec[0], 1'b1, "R4", "unpredicated ALU slot");
        check(slot_exec[1], 1'b1, "R4", "slot on set predicate");
        check(slot_exec[2], 1'b0, "R4", "slot on clear predicate");
        @(negedge clk);
        slot_valid = 3'b000; slot_pred_en = 3'b111;
        slot_pred_idx = {5'd5, 5'd5, 5'd5};
        #1;
        check(slot_exec != 3'b000, 1'b0, "R5", "invalid slots on set predicate");
        slot_pred_en = 3'b000;
        #1;
        check(slot_exec != 3'b000, 1'b0, "R5", "invalid unpredicated slots");
        @(negedge clk);
        slot_valid = 3'b001; slot_pred_en = 3'b001; slot_pred_idx = {10'd0, 5'd6};
        alu_is_branch = 1'b1;
        #1;
        check(slot_exec[0], 1'b1, "R6", "branch on clear predicate");
        alu_is_branch = 1'b0;
        #1;
        check(slot_exec[0], 1'b0, "R4", "ALU op on clear predicate");
        idle();
    endtask

    task automatic t_same_cycle();
        issue_cmp(0, 4, 12, 32'd1);
        @(negedge clk);
        set_cmp(0, 2, 12, 32'd9);
        slot_valid[2] = 1'b1; slot_pred_en[2] = 1'b1; slot_pred_idx[10 +: 5] = 5'd12;
        #1;
        check(slot_exec[2], 1'b0, "R7", "read before same-cycle write");
        @(negedge clk);
        cmp_valid = '0;
        exp_p[12] = 1'b1;
        #1;
        check(slot_exec[2], 1'b1, "R7", "write seen next cycle");
        idle();
    endtask

    task automatic t_clash();
        issue_cmp(0, 2, 9, 32'd1);
        @(negedge clk);
        set_cmp(0, 0, 9, 32'd4);
        set_cmp(1, 4, 9, 32'd3);
        #1;
        check(bundle_illegal, 1'b1, "R8", "double write flagged");
        @(negedge clk);
        idle();
        #1;
        check(bundle_illegal, 1'b0, "R8", "flag clears");
        probe(9, "R8");
        @(negedge clk);
        set_cmp(0, 7, 9, 32'd1);
        set_cmp(1, 2, 9, 32'hFFFF_FFFF);
        #1;
        check(bundle_illegal, 1'b0, "R3", "reserved code no clash");
        exp_p[9] = 1'b0;
        @(negedge clk);
        idle();
        probe(9, "R3");
    endtask

    task automatic t_pair();
        @(negedge clk);
        set_cmp(0, 2, 30, 32'd1);
        set_cmp(1, 1, 31, 32'd0);
        #1;
        check(bundle_illegal, 1'b0, "R9", "distinct destinations legal");
        exp_p[30] = 1'b1; exp_p[31] = 1'b1;
        @(negedge clk);
        idle();
        probe(30, "R9");
        probe(31, "R9");
    endtask

    task automatic t_hold();
        repeat (10) @(negedge clk);
        probe(30, "R10");
        probe(31, "R10");
        probe(9, "R10");
        probe(12, "R10");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) exp_p[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_compares();
        t_reserved();
        t_gating();
        t_same_cycle();
        t_clash();
        t_pair();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule